// File: doc/BRIEF.md
# Strict-Priority Weighted Sibling Arbiter

This block picks one winner per clock among up to `N_SIB` sibling scheduling nodes that share a parent. Each sibling brings a request bit, a blocked bit and an over-limit bit from an external rate meter. A sibling competes only when it is requesting, not blocked and not over its limit. Among the competitors, the block first keeps only those at the highest effective priority present. Inside that set it picks the sibling with the smallest virtual-finish counter, so siblings that share a priority level divide service in proportion to their weights.

Each sibling's priority and weight are loaded through a small write port. Byte accounting comes back on a separate feedback port: after a grant has been used, the consumer reports the sibling index and the byte count. That sibling's counter then advances by the byte count times a scaled reciprocal of its weight. To form a hierarchy, instantiate one arbiter per tree level and feed a parent's grant into its children's request bits.

The counters stay bounded in two ways. A sibling that is not competing is pulled up to the minimum counter of the current contenders, so it cannot bank credit while idle or starved. When any counter reaches its top bit, the smallest counter is subtracted from all of them.

Top module: `sp_wfq_arbiter`

## Requirements
- R1: After reset, `grant_o` is all zeros, `grant_idx_o` is 0 and `grant_valid_o` is 0. Every sibling has control word 0 (effective priority 0) and weight 1.
- R2: A sibling is eligible only when `req_i` is 1, `blocked_i` is 0 and `over_limit_i` is 0. If no sibling is eligible, the next registered result has `grant_valid_o` = 0 and `grant_o` = 0.
- R3: The control word written on `cfg_ctrl_i` uses bits [3:1] as the priority and bit 4 as the strict-priority enable; bit 0 is a stored mode bit with no effect on arbitration. The effective priority is bits [3:1] when bit 4 is 1 and 0 otherwise, and 7 is the highest level. The winner always comes from the highest effective level that has an eligible sibling, so a lower level is served only when no sibling at a higher level is eligible.
- R4: The result is registered: requests sampled at a rising edge produce the grant right after that edge. `grant_o` is one-hot when `grant_valid_o` is 1, and bit `grant_idx_o` is the set bit.
- R5: Within the winning level, the sibling with the smallest virtual-finish counter wins. On equal counters, the lowest index wins.
- R6: A charge (`charge_en_i` = 1) adds `charge_bytes_i` × (`RECIP_NUM` / weight) to the counter of sibling `charge_idx_i`. Service therefore follows the weight ratio and the bytes consumed.
- R7: A weight written as 0 is stored as 1. A weight above 200 is stored as 200.
- R8: While some sibling is contending, any sibling outside the contending group has its counter raised to the group's minimum counter if it is lower.
- R9: When any counter has its top bit set, the smallest counter is subtracted from every counter. Order is preserved and no counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SIB | Per-sibling request |
| blocked_i | input | N_SIB | Per-sibling blocked flag |
| over_limit_i | input | N_SIB | Per-sibling over-rate flag from an external meter |
| cfg_wr_i | input | 1 | Write strobe for one sibling's configuration |
| cfg_sel_i | input | IDX_W | Sibling selected for the write |
| cfg_ctrl_i | input | 5 | Control word: [0] mode, [3:1] priority, [4] strict-priority enable |
| cfg_weight_i | input | WEIGHT_W | Weight, clamped to 1..200 |
| charge_en_i | input | 1 | Byte-accounting feedback valid |
| charge_idx_i | input | IDX_W | Sibling to charge |
| charge_bytes_i | input | BYTES_W | Bytes consumed by that grant |
| grant_o | output | N_SIB | One-hot registered grant |
| grant_idx_o | output | IDX_W | Index of the granted sibling |
| grant_valid_o | output | 1 | A grant is present |

## Verification
The bench targets the boundaries of the priority cascade:
- It blocks or rate-limits the top level one sibling at a time. A design that fell through to lower levels too early, or that ignored the enable bit, would grant the wrong index.
- It runs equal-counter ties. A design that broke ties toward the higher index would flip the expected grant order.
- It drives weights of 0 and 255. A missing clamp shows as a division by zero, or as an uneven alternation between siblings whose weights should end up equal.
- It leaves one sibling idle while another is served, then lets it join. Without the catch-up, the late sibling would win many grants in a row.
- It pushes large byte counts for dozens of rounds. Without the rebase, the counters would wrap and one sibling would win repeatedly.

// File: rtl/spwfq_pkg.sv
package spwfq_pkg;
   // control word layout
   localparam int unsigned CTRL_W        = 5;
   localparam int unsigned CTRL_MODE_BIT = 0;
   localparam int unsigned CTRL_PRIO_LSB = 1;
   localparam int unsigned PRIO_W        = 3;
   localparam int unsigned CTRL_SP_BIT   = 4;
   // legal weight range
   localparam int unsigned WEIGHT_MIN    = 1;
   localparam int unsigned WEIGHT_MAX    = 200;
endpackage

// File: rtl/spwfq_cfg_regs.sv
module spwfq_cfg_regs
   import spwfq_pkg::*;
#(
   parameter int unsigned N_SIB     = 8,
   parameter int unsigned IDX_W     = 3,
   parameter int unsigned WEIGHT_W  = 8,
   parameter int unsigned RECIP_W   = 20,
   parameter int unsigned RECIP_NUM = 720720
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_i,
   input  logic [IDX_W-1:0]                   sel_i,
   input  logic [CTRL_W-1:0]                  ctrl_i,
   input  logic [WEIGHT_W-1:0]                weight_i,
   output logic [N_SIB-1:0][PRIO_W-1:0]       eff_prio_o,
   output logic [N_SIB-1:0][RECIP_W-1:0]      recip_o
);

   function automatic logic [WEIGHT_W-1:0] clamp_w(input logic [WEIGHT_W-1:0] w);
      if (w == '0)
         return WEIGHT_W'(WEIGHT_MIN);
      else if (w > WEIGHT_W'(WEIGHT_MAX))
         return WEIGHT_W'(WEIGHT_MAX);
      else
         return w;
   endfunction

   logic [WEIGHT_W-1:0] w_clamped;
   logic [RECIP_W-1:0]  recip_new;

   assign w_clamped = clamp_w(weight_i);
   assign recip_new = RECIP_W'(RECIP_NUM) / RECIP_W'(w_clamped);

   for (genvar s = 0; s < N_SIB; s++) begin : g_sib
      logic [PRIO_W-1:0]   prio_q;
      logic                sp_q;
      logic                mode_q;
      logic [WEIGHT_W-1:0] wgt_q;
      logic [RECIP_W-1:0]  recip_q;
      logic                hit;

      assign hit = wr_i && (sel_i == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q  <= '0;
            sp_q    <= 1'b0;
            mode_q  <= 1'b0;
            wgt_q   <= WEIGHT_W'(WEIGHT_MIN);
            recip_q <= RECIP_W'(RECIP_NUM);
         end else if (hit) begin
            prio_q  <= ctrl_i[CTRL_PRIO_LSB +: PRIO_W];
            sp_q    <= ctrl_i[CTRL_SP_BIT];
            mode_q  <= ctrl_i[CTRL_MODE_BIT];
            wgt_q   <= w_clamped;
            recip_q <= recip_new;
         end
      end

      assign eff_prio_o[s] = sp_q ? prio_q : '0;
      assign recip_o[s]    = recip_q;

      AST_WEIGHT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (wgt_q >= WEIGHT_W'(WEIGHT_MIN)) && (wgt_q <= WEIGHT_W'(WEIGHT_MAX))); // R7
      AST_RECIP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (recip_q != '0) || (mode_q && !mode_q)); // R6
   end

endmodule

// File: rtl/spwfq_prio_select.sv
module spwfq_prio_select #(
   parameter int unsigned N_SIB  = 8,
   parameter int unsigned PRIO_W = 3
) (
   input  logic [N_SIB-1:0]              elig_i,
   input  logic [N_SIB-1:0][PRIO_W-1:0]  prio_i,
   output logic                          any_o,
   output logic [N_SIB-1:0]              group_o
);

   localparam int unsigned LEVELS = 1 << PRIO_W;

   logic [LEVELS-1:0] lvl_hit;
   logic [PRIO_W-1:0] top_lvl;

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      logic [N_SIB-1:0] at_lvl;
      for (genvar s = 0; s < N_SIB; s++) begin : g_s
         assign at_lvl[s] = elig_i[s] && (prio_i[s] == PRIO_W'(l));
      end
      assign lvl_hit[l] = |at_lvl;
   end

   // ascending scan: the last (highest) occupied level wins
   always_comb begin
      top_lvl = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (lvl_hit[l]) top_lvl = PRIO_W'(l);
      end
   end

   assign any_o = |lvl_hit;

   for (genvar s = 0; s < N_SIB; s++) begin : g_grp
      assign group_o[s] = elig_i[s] && (prio_i[s] == top_lvl);
   end

endmodule

// File: rtl/spwfq_argmin.sv
module spwfq_argmin #(
   parameter int unsigned N_SIB = 8,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned VAL_W = 34
) (
   input  logic [N_SIB-1:0]             cand_i,
   input  logic [N_SIB-1:0][VAL_W-1:0]  val_i,
   output logic                         any_o,
   output logic [IDX_W-1:0]             idx_o,
   output logic [VAL_W-1:0]             min_o
);

   // strict less-than keeps the lowest index on a tie
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      min_o = '0;
      for (int s = 0; s < N_SIB; s++) begin
         if (cand_i[s] && (!any_o || (val_i[s] < min_o))) begin
            any_o = 1'b1;
            idx_o = IDX_W'(s);
            min_o = val_i[s];
         end
      end
   end

endmodule

// File: rtl/spwfq_vft_bank.sv
module spwfq_vft_bank #(
   parameter int unsigned N_SIB   = 8,
   parameter int unsigned IDX_W   = 3,
   parameter int unsigned BYTES_W = 12,
   parameter int unsigned RECIP_W = 20,
   parameter int unsigned VFT_W   = 34
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_SIB-1:0]              group_i,
   input  logic                          group_any_i,
   input  logic [VFT_W-1:0]              group_min_i,
   input  logic                          charge_en_i,
   input  logic [IDX_W-1:0]              charge_idx_i,
   input  logic [BYTES_W-1:0]            charge_bytes_i,
   input  logic [N_SIB-1:0][RECIP_W-1:0] recip_i,
   output logic [N_SIB-1:0][VFT_W-1:0]   vft_o
);

   localparam int unsigned PROD_W = BYTES_W + RECIP_W;

   logic [N_SIB-1:0][VFT_W-1:0] vft_q;
   logic [N_SIB-1:0]            top_set;
   logic                        rebase;
   logic [VFT_W-1:0]            all_min;

   always_comb begin
      all_min = vft_q[0];
      for (int s = 1; s < N_SIB; s++) begin
         if (vft_q[s] < all_min) all_min = vft_q[s];
      end
   end

   for (genvar s = 0; s < N_SIB; s++) begin : g_top
      assign top_set[s] = vft_q[s][VFT_W-1];
   end
   assign rebase = |top_set;

   for (genvar s = 0; s < N_SIB; s++) begin : g_ctr
      logic [PROD_W-1:0] prod;
      logic [VFT_W-1:0]  base;
      logic [VFT_W-1:0]  add;
      logic [VFT_W-1:0]  sub;
      logic              lift;

      assign prod = PROD_W'(charge_bytes_i) * PROD_W'(recip_i[s]);
      assign lift = group_any_i && !group_i[s] && (vft_q[s] < group_min_i);
      assign base = lift ? group_min_i : vft_q[s];
      assign add  = (charge_en_i && (charge_idx_i == IDX_W'(s))) ? VFT_W'(prod) : '0;
      assign sub  = rebase ? all_min : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vft_q[s] <= '0;
         else        vft_q[s] <= base - sub + add;
      end

      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         !(vft_q[s][VFT_W-1] && vft_q[s][VFT_W-2])); // R9
      AST_LIFT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
         (group_any_i && !group_i[s] && !rebase) |=> (vft_q[s] >= $past(group_min_i))); // R8
   end

   assign vft_o = vft_q;

endmodule

// File: rtl/sp_wfq_arbiter.sv
module sp_wfq_arbiter
   import spwfq_pkg::*;
#(
   parameter int unsigned N_SIB     = 8,
   parameter int unsigned WEIGHT_W  = 8,
   parameter int unsigned BYTES_W   = 12,
   parameter int unsigned RECIP_NUM = 720720,
   localparam int unsigned IDX_W    = (N_SIB > 1) ? $clog2(N_SIB) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_SIB-1:0]     req_i,
   input  logic [N_SIB-1:0]     blocked_i,
   input  logic [N_SIB-1:0]     over_limit_i,
   input  logic                 cfg_wr_i,
   input  logic [IDX_W-1:0]     cfg_sel_i,
   input  logic [CTRL_W-1:0]    cfg_ctrl_i,
   input  logic [WEIGHT_W-1:0]  cfg_weight_i,
   input  logic                 charge_en_i,
   input  logic [IDX_W-1:0]     charge_idx_i,
   input  logic [BYTES_W-1:0]   charge_bytes_i,
   output logic [N_SIB-1:0]     grant_o,
   output logic [IDX_W-1:0]     grant_idx_o,
   output logic                 grant_valid_o
);

   localparam int unsigned RECIP_W = $clog2(RECIP_NUM + 1);
   localparam int unsigned VFT_W   = BYTES_W + RECIP_W + 2;

   if (N_SIB < 2 || N_SIB > 64) begin : g_bad_nsib
      $error("N_SIB must lie in 2..64");
   end
   if (WEIGHT_W < 8) begin : g_bad_wgt
      $error("WEIGHT_W must hold the value 200");
   end
   if (RECIP_NUM < WEIGHT_MAX) begin : g_bad_recip
      $error("RECIP_NUM must be at least the maximum weight");
   end

   logic [N_SIB-1:0]              elig;
   logic [N_SIB-1:0][PRIO_W-1:0]  eff_prio;
   logic [N_SIB-1:0][RECIP_W-1:0] recip;
   logic [N_SIB-1:0][VFT_W-1:0]   vft;
   logic [N_SIB-1:0]              group;
   logic                          group_any;
   logic                          win_any;
   logic [IDX_W-1:0]              win_idx;
   logic [VFT_W-1:0]              win_min;

   assign elig = req_i & ~blocked_i & ~over_limit_i;

   spwfq_cfg_regs #(
      .N_SIB(N_SIB), .IDX_W(IDX_W), .WEIGHT_W(WEIGHT_W),
      .RECIP_W(RECIP_W), .RECIP_NUM(RECIP_NUM)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_i(cfg_wr_i), .sel_i(cfg_sel_i), .ctrl_i(cfg_ctrl_i), .weight_i(cfg_weight_i),
      .eff_prio_o(eff_prio), .recip_o(recip)
   );

   spwfq_prio_select #(
      .N_SIB(N_SIB), .PRIO_W(PRIO_W)
   ) i_prio (
      .elig_i(elig), .prio_i(eff_prio), .any_o(group_any), .group_o(group)
   );

   spwfq_argmin #(
      .N_SIB(N_SIB), .IDX_W(IDX_W), .VAL_W(VFT_W)
   ) i_min (
      .cand_i(group), .val_i(vft), .any_o(win_any), .idx_o(win_idx), .min_o(win_min)
   );

   spwfq_vft_bank #(
      .N_SIB(N_SIB), .IDX_W(IDX_W), .BYTES_W(BYTES_W),
      .RECIP_W(RECIP_W), .VFT_W(VFT_W)
   ) i_vft (
      .clk(clk), .rst_n(rst_n),
      .group_i(group), .group_any_i(group_any), .group_min_i(win_min),
      .charge_en_i(charge_en_i), .charge_idx_i(charge_idx_i),
      .charge_bytes_i(charge_bytes_i), .recip_i(recip), .vft_o(vft)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_o       <= '0;
         grant_idx_o   <= '0;
         grant_valid_o <= 1'b0;
      end else begin
         grant_o       <= win_any ? (N_SIB'(1) << win_idx) : '0;
         grant_idx_o   <= win_any ? win_idx : '0;
         grant_valid_o <= win_any;
      end
   end

   // snapshots of what the arbitration saw, for the checks below
   logic [N_SIB-1:0]             elig_seen_q;
   logic [N_SIB-1:0][PRIO_W-1:0] prio_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elig_seen_q <= '0;
         prio_seen_q <= '0;
      end else begin
         elig_seen_q <= elig;
         prio_seen_q <= eff_prio;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && (grant_valid_o == (|grant_o))); // R4
   AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> grant_o[grant_idx_o]); // R4
   AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> elig_seen_q[grant_idx_o]); // R2
   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (elig_seen_q == '0) |-> (!grant_valid_o && (grant_o == '0))); // R2

   for (genvar s = 0; s < N_SIB; s++) begin : g_prio_chk
      AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
         (grant_valid_o && elig_seen_q[s]) |-> (prio_seen_q[s] <= prio_seen_q[grant_idx_o])); // R3
   end

endmodule

// File: tb/test_sp_wfq_arbiter.sv
`timescale 1ns/1ps
module test_sp_wfq_arbiter;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req = '0, blk = '0, ovl = '0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [4:0]  cfg_ctrl = '0;
   logic [7:0]  cfg_weight = '0;
   logic        ch_en = 1'b0;
   logic [2:0]  ch_idx = '0;
   logic [11:0] ch_bytes = '0;
   logic [7:0]  grant;
   logic [2:0]  gidx;
   logic        gvalid;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sp_wfq_arbiter #(.N_SIB(N)) i_sp_wfq_arbiter (
      .clk(clk), .rst_n(rst_n),
      .req_i(req), .blocked_i(blk), .over_limit_i(ovl),
      .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_ctrl_i(cfg_ctrl), .cfg_weight_i(cfg_weight),
      .charge_en_i(ch_en), .charge_idx_i(ch_idx), .charge_bytes_i(ch_bytes),
      .grant_o(grant), .grant_idx_o(gidx), .grant_valid_o(gvalid)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req = '0; blk = '0; ovl = '0; cfg_wr = 1'b0; ch_en = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic set_cfg(input int idx, input logic [4:0] ctrl, input logic [7:0] w);
      cfg_wr = 1'b1; cfg_sel = 3'(idx); cfg_ctrl = ctrl; cfg_weight = w;
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // one arbitration: drive at negedge, observe after the next edge
   task automatic arb(input logic [7:0] r, input logic [7:0] b, input logic [7:0] o);
      req = r; blk = b; ovl = o;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_grant(input string tag, input int exp_idx);
      chk({tag, " valid"}, gvalid, 1);
      chk({tag, " idx"}, gidx, exp_idx);
      chk({tag, " onehot"}, grant, 8'(1) << exp_idx);
   endtask

   // grant then charge the granted sibling
   task automatic wfq_round(input logic [7:0] r, input logic [11:0] bytes,
                            input int exp_idx, input string tag);
      arb(r, '0, '0);
      expect_grant(tag, exp_idx);
      req = '0; ch_en = 1'b1; ch_idx = gidx; ch_bytes = bytes;
      @(posedge clk);
      @(negedge clk);
      ch_en = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 reset valid", gvalid, 0);
      chk("R1 reset grant", grant, 0);
      chk("R1 reset idx", gidx, 0);
      // default config: all at priority 0 with equal counters, lowest index wins
      arb(8'b1100_0000, '0, '0);
      expect_grant("R1 default cfg", 6);
   endtask

   task automatic t_latency();
      do_reset();
      req = 8'b0000_0100;
      #1;
      chk("R4 no grant before edge", gvalid, 0);
      @(posedge clk);
      @(negedge clk);
      expect_grant("R4 grant after edge", 2);
      req = '0;
      #1;
      chk("R4 grant held until edge", gvalid, 1);
      @(posedge clk);
      @(negedge clk);
      chk("R4 drop after edge", gvalid, 0);
   endtask

   task automatic t_priority();
      do_reset();
      // ctrl: [4]=enable [3:1]=priority [0]=mode
      set_cfg(0, 5'b1_010_0, 8'd1);   // prio 2
      set_cfg(1, 5'b1_101_0, 8'd1);   // prio 5
      set_cfg(2, 5'b0_101_1, 8'd1);   // enable clear -> effective 0
      set_cfg(7, 5'b1_111_0, 8'd1);   // prio 7
      arb(8'b0000_0111, '0, '0);
      expect_grant("R3 highest level", 1);
      arb(8'b0000_0111, 8'b0000_0010, '0);
      expect_grant("R3 fall to next level when blocked", 0);
      arb(8'b0000_0111, 8'b0000_0010, 8'b0000_0001);
      expect_grant("R2 over-limit excluded", 2);
      arb(8'b0000_0100, 8'b0000_0100, '0);
      chk("R2 none eligible valid", gvalid, 0);
      chk("R2 none eligible grant", grant, 0);
      arb(8'b0000_0000, '0, 8'b1111_1111);
      chk("R2 idle valid", gvalid, 0);
      arb(8'b0000_1100, '0, '0);
      expect_grant("R5 tie goes to lowest index", 2);
      arb(8'b1000_0011, '0, '0);
      expect_grant("R3 level 7 first", 7);
      arb(8'b1000_0011, '0, 8'b1000_0000);
      expect_grant("R3 level 7 over limit", 1);
   endtask

   task automatic t_weights();
      int exp_seq[6] = '{0, 1, 0, 0, 1, 0};
      do_reset();
      set_cfg(0, 5'b1_011_0, 8'd2);
      set_cfg(1, 5'b1_011_0, 8'd1);
      for (int k = 0; k < 6; k++) wfq_round(8'b0000_0011, 12'd100, exp_seq[k], "R6 weight 2:1");
   endtask

   task automatic t_bytes();
      int exp_seq[5] = '{0, 1, 1, 1, 0};
      do_reset();
      for (int k = 0; k < 5; k++)
         wfq_round(8'b0000_0011, (exp_seq[k] == 0) ? 12'd300 : 12'd100, exp_seq[k], "R6 bytes 3:1");
   endtask

   task automatic t_clamp();
      do_reset();
      set_cfg(0, 5'b0, 8'd0);        // clamps to 1
      set_cfg(1, 5'b0, 8'd1);
      for (int k = 0; k < 6; k++) wfq_round(8'b0000_0011, 12'd50, k % 2, "R7 zero weight");
      do_reset();
      set_cfg(0, 5'b0, 8'd255);      // clamps to 200
      set_cfg(1, 5'b0, 8'd200);
      for (int k = 0; k < 6; k++) wfq_round(8'b0000_0011, 12'd50, k % 2, "R7 saturated weight");
   endtask

   task automatic t_catchup();
      int exp_seq[4] = '{1, 0, 1, 0};
      do_reset();
      for (int k = 0; k < 5; k++) wfq_round(8'b0000_0001, 12'd100, 0, "R8 solo service");
      for (int k = 0; k < 4; k++) wfq_round(8'b0000_0011, 12'd100, exp_seq[k], "R8 late joiner");
   endtask

   task automatic t_rebase();
      do_reset();
      for (int k = 0; k < 30; k++) wfq_round(8'b0000_0011, 12'd4095, k % 2, "R9 long run");
   endtask

   initial begin
      t_reset();
      t_latency();
      t_priority();
      t_weights();
      t_bytes();
      t_clamp();
      t_catchup();
      t_rebase();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errs++;
         $display("FAIL watchdog: actual=expired expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule